// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Address Filter

This block is the receive half of an asynchronous serial port running in multiprocessor mode. A baud generator supplies a sample strobe at a fixed multiple of the bit rate. The block finds the start bit, shifts in the data bits least significant bit first, then reads one extra flag bit and the stop bit or bits. When the flag bit is 1 the frame is an address frame. When it is 0 the frame is a data frame.

Address frames are compared against the station's own address. A match selects the station. A mismatch deselects it. Data frames are passed to the output only while the station is selected. The address byte itself never appears on the data output. A separate one-cycle pulse reports each matching address.

A frame whose stop bit is sampled low is reported as a framing error. Such a frame is neither delivered nor used for address matching.

Top module: `mp_addr_rx`

## Requirements
- R1: With `cfg_7bit`=0 a frame is: a low start bit, 8 data bits least significant bit first, the flag bit, then the stop bit(s). Each bit lasts `OSR` strobes. Results appear as registered one-cycle pulses on the clock after the sample of the last stop bit.
- R2: A low line seen on a strobe while idle starts a frame only if the line is still low `OSR/2` strobes later. If the line is high there, the block returns to idle and reports nothing.
- R3: A good frame with flag 1 whose zero-extended byte equals `own_addr` pulses `addr_hit`, sets `selected`, and leaves `rx_valid` low.
- R4: A good frame with flag 1 that does not equal `own_addr` clears `selected` and raises no pulse.
- R5: A good frame with flag 0 pulses `rx_valid` with the byte on `rx_byte` only while `selected` is 1. Otherwise it is dropped and no output moves.
- R6: With `cfg_7bit`=1 the flag bit follows data bit 6. `rx_byte` bit 7 and bit 7 of the compared address are 0.
- R7: With `cfg_2stop`=1 both stop bits are sampled, and the result follows the second one. With `cfg_2stop`=0 only one stop bit is sampled.
- R8: Any stop bit sampled low pulses `frame_err` instead of `rx_valid` or `addr_hit`, and leaves `selected` unchanged.
- R9: The receive state advances only on cycles where `tick` is 1. A low line during cycles without a strobe starts nothing.
- R10: After reset `rx_valid`, `frame_err`, `addr_hit`, `selected` and `rx_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, already synchronous to clk, idle high |
| tick | input | 1 | Sample strobe, OSR per bit time |
| cfg_7bit | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_2stop | input | 1 | 1: two stop bits, 0: one |
| own_addr | input | 8 | Station address |
| rx_byte | output | 8 | Last delivered data byte |
| rx_valid | output | 1 | One-cycle pulse: data byte delivered |
| frame_err | output | 1 | One-cycle pulse: stop bit sampled low |
| addr_hit | output | 1 | One-cycle pulse: matching address received |
| selected | output | 1 | Station currently addressed |

## Verification
A corrupt selection bit shows at the ports within a single frame. `selected` is compared on every cycle, and the next data frame is either delivered or dropped against expectation. A wrong sample counter or bit count moves the result pulse off its predicted cycle, or it shifts the assembled byte, and this is visible at the end of the first frame affected. A start or stop state that ignores the strobe or skips the mid-bit recheck turns a glitch into a spurious address frame. That frame drops `selected` during the next frame time.

// File: rtl/mp_addr_rx.sv
module mp_addr_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       tick,
  input  logic       cfg_7bit,
  input  logic       cfg_2stop,
  input  logic [7:0] own_addr,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       frame_err,
  output logic       addr_hit,
  output logic       selected
);
  localparam int CW   = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int HALF = OSR / 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [3:0]    nbit;
  logic [8:0]    sh;
  logic          w7, s2, stop_ok, second;

  wire       last_cnt = (cnt == CW'(OSR - 1));
  wire       mid_cnt  = (cnt == CW'(HALF - 1));
  wire [3:0] nframe   = w7 ? 4'd8 : 4'd9;
  wire [7:0] got      = w7 ? {1'b0, sh[7:1]} : sh[7:0];
  wire       flag     = sh[8];
  wire       ok       = stop_ok & rxd;
  wire       match    = (got == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; nbit <= '0; sh <= '0;
      w7 <= 1'b0; s2 <= 1'b0; stop_ok <= 1'b1; second <= 1'b0;
      rx_byte <= '0; rx_valid <= 1'b0; frame_err <= 1'b0;
      addr_hit <= 1'b0; selected <= 1'b0;
    end else begin
      rx_valid <= 1'b0; frame_err <= 1'b0; addr_hit <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: if (!rxd) begin
            st <= S_START; cnt <= '0; w7 <= cfg_7bit; s2 <= cfg_2stop;
          end
          S_START: if (mid_cnt) begin
            cnt <= '0; nbit <= '0;
            st <= rxd ? S_IDLE : S_BITS;
          end else cnt <= cnt + 1'b1;
          S_BITS: if (last_cnt) begin
            cnt <= '0;
            sh <= {rxd, sh[8:1]};
            nbit <= nbit + 1'b1;
            if (nbit == nframe - 4'd1) begin
              st <= S_STOP; stop_ok <= 1'b1; second <= 1'b0;
            end
          end else cnt <= cnt + 1'b1;
          S_STOP: if (last_cnt) begin
            cnt <= '0;
            if (s2 && !second) begin
              second <= 1'b1; stop_ok <= rxd;
            end else begin
              st <= S_IDLE;
              frame_err <= !ok;
              if (ok) begin
                if (flag) begin
                  selected <= match;
                  addr_hit <= match;
                end else if (selected) begin
                  rx_valid <= 1'b1;
                  rx_byte  <= got;
                end
              end
            end
          end else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r5_valid_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> selected);
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, frame_err, addr_hit}));
  a_r3_hit_selects: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> selected);
  a_r8_err_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $stable(selected));
  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(st) && $stable(cnt)));
  a_r6_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && w7) |-> !rx_byte[7]);
endmodule

// File: tb/mp_addr_rx_bench.sv
module mp_addr_rx_bench;
  localparam int OSR  = 16;
  localparam int HALF = OSR / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, tick = 1'b1, cfg_7bit = 1'b0, cfg_2stop = 1'b0;
  logic [7:0] own_addr = 8'h5A;
  logic [7:0] rx_byte;
  logic rx_valid, frame_err, addr_hit, selected;

  always #2.5 clk = ~clk;

  mp_addr_rx #(.OSR(OSR)) u_mp_addr_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick), .cfg_7bit(cfg_7bit),
    .cfg_2stop(cfg_2stop), .own_addr(own_addr), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .frame_err(frame_err), .addr_hit(addr_hit),
    .selected(selected));

  int cyc = 0;
  int vectors = 0, errors = 0;
  int exp_cyc = -1, exp_kind = 0;
  logic [7:0] exp_byte = 8'h00;
  bit exp_sel_after = 1'b0, sel_m = 1'b0, done = 1'b0;
  string cur_req = "R10";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit hit_now;
    hit_now = (cyc == exp_cyc);
    if (hit_now && exp_kind == 3) sel_m = 1'b1;
    if (hit_now && exp_kind == 0 && exp_sel_after == 1'b0) sel_m = 1'b0;
    chk(cur_req, "rx_valid", int'(rx_valid), int'(hit_now && exp_kind == 1));
    chk(cur_req, "frame_err", int'(frame_err), int'(hit_now && exp_kind == 2));
    chk(cur_req, "addr_hit", int'(addr_hit), int'(hit_now && exp_kind == 3));
    chk(cur_req, "selected", int'(selected), int'(sel_m));
    if (hit_now && exp_kind == 1) chk(cur_req, "rx_byte", int'(rx_byte), int'(exp_byte));
  end

  // flag: ninth bit; st1/st2: levels driven on the stop bits
  task automatic send(input logic [7:0] b, input bit flag, input bit w7, input bit s2,
                      input bit st1, input bit st2);
    int nb, nst, det;
    bit ok;
    logic [7:0] d;
    @(negedge clk);
    cfg_7bit = w7; cfg_2stop = s2;
    nb  = w7 ? 8 : 9;
    nst = s2 ? 2 : 1;
    d   = w7 ? {1'b0, b[6:0]} : b;
    ok  = st1 && (s2 ? st2 : 1'b1);
    @(negedge clk);
    det = cyc + 1;
    exp_byte = d;
    exp_sel_after = sel_m;
    if (!ok) exp_kind = 2;
    else if (flag) begin
      exp_kind = (d == own_addr) ? 3 : 0;
      exp_sel_after = (d == own_addr);
    end else exp_kind = sel_m ? 1 : 4;
    exp_cyc = det + HALF + OSR * (nb + nst);
    rxd = 1'b0;
    repeat (OSR) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      rxd = (k == nb - 1) ? flag : d[k];
      repeat (OSR) @(negedge clk);
    end
    rxd = st1;
    repeat (OSR) @(negedge clk);
    if (s2) begin
      rxd = st2;
      repeat (OSR) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * OSR) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10", "rx_valid", int'(rx_valid), 0);
    chk("R10", "frame_err", int'(frame_err), 0);
    chk("R10", "addr_hit", int'(addr_hit), 0);
    chk("R10", "selected", int'(selected), 0);
    chk("R10", "rx_byte", int'(rx_byte), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R5";  send(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    cur_req = "R3";  send(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    cur_req = "R1";  send(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    cur_req = "R1";  send(8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    cur_req = "R7";  send(8'h81, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);

    cur_req = "R9";
    @(negedge clk); tick = 1'b0; rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (2) @(negedge clk);
    tick = 1'b1;
    repeat (3 * OSR * 12) @(negedge clk);

    cur_req = "R2";
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (OSR * 13) @(negedge clk);

    cur_req = "R8";  send(8'h11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    cur_req = "R8";  send(8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    cur_req = "R5";  send(8'h66, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    cur_req = "R4";  send(8'h33, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    cur_req = "R5";  send(8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    cur_req = "R8";  send(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    cur_req = "R6";  send(8'hDA, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    cur_req = "R6";  send(8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    cur_req = "R7";  send(8'h0F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    cur_req = "R4";  send(8'h5B, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);

    done = 1'b1;
    summary();
  end
endmodule